// File: doc/BRIEF.md
# Clock Output Stop and Park Controller

This block decides, for each of a parameterised number of differential clock outputs, whether the output runs or is parked. Each output is modelled as a true level, a complement level and a drive-enable flag for each leg, so that the analog output stage can either follow the levels or float. All outputs are derived from one internal reference clock. A rate select picks either the full output rate or half of it.

Each output runs when its register enable bit is set and its pin gate allows it. An output whose stoppable bit is clear ignores its active-low enable pin. An output whose stoppable bit is set runs only while that pin is low. An asynchronous active-low power-down input is synchronised and then qualified on two consecutive complement rising edges, after which every output parks. Outputs start, stop, park and resume only at the edge where the complement leg falls and the true leg rises, so neither leg ever shows a runt pulse. Two separate park-style bits, one for power-down and one for ordinary stops, choose the parked shape: either the true leg is driven high with the complement floating, or both legs float.

Top module: `clkpark_ctrl`

## Requirements
- R1: While reset is held, every leg of every output is undriven (both drive-enable flags 0).
- R2: An output runs only when its register enable bit is 1 and either its stoppable bit is 0 or its active-low enable pin is 0. Otherwise it is parked. A pin change on a free-running output has no effect.
- R3: A running output drives both legs (both enable flags 1), and the complement level is always the inverse of the true level.
- R4: With the rate select at 1, a running true leg toggles on every reference clock cycle. With the rate select at 0, it toggles every second reference cycle.
- R5: An output parked by a stop, rather than by power-down, follows the stop park-style bit. With the bit at 0, the true leg is driven high and the complement floats. With the bit at 1, both legs float.
- R6: During power-down, all outputs park according to the power-down park-style bit, using the same encoding as R5.
- R7: Power-down takes effect only after the synchronised power-down input has been seen low at two consecutive complement rising edges. A low pulse that spans only one such edge changes nothing at the outputs. A qualified power-down parks all outputs later than two reference cycles after the input falls.
- R8: An output changes between running and parked only at the edge where its true leg goes from low to high. A stopping output's true leg was low just before that edge, and a starting output's true leg is high just after it.
- R9: After a change on an output's enable pin, or on its register bits, the output reaches its new run or park state within three output periods.
- R10: When power-down is released, every output resumes according to its current enable, stoppable and pin values and the current stop park-style bit. Changes made while powered down therefore take effect on resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| full_rate | input | 1 | 1 selects the full output rate, 0 selects half rate |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| oe_n | input | NUM_OUT | Active-low per-output enable pins |
| reg_en | input | NUM_OUT | Register enable bit per output (1 = allowed to run) |
| reg_stop | input | NUM_OUT | Register stoppable bit per output (1 = pin gates output) |
| oe_park_float | input | 1 | Park style for stops (0 = true high, 1 = both float) |
| pd_park_float | input | 1 | Park style for power-down (same encoding) |
| out_t | output | NUM_OUT | True leg level |
| out_c | output | NUM_OUT | Complement leg level |
| out_t_en | output | NUM_OUT | True leg drive enable |
| out_c_en | output | NUM_OUT | Complement leg drive enable |

## Verification
The bench builds the block with four outputs, two synchroniser stages and a two-edge power-down qualification. With that configuration, rotating a three-bit pattern (enable, stoppable, pin) across the four outputs reaches all eight gating combinations within eight steps. Each step is repeated for both rates and both stop park styles, and the power-down sequences are repeated for both rates and both power-down park styles. Because the phase counter is small at this size, the two-cycle power-down pulse, the release-with-changed-settings case and every run/park transition edge can all be observed directly.

// File: rtl/clkpark_pkg.sv
package clkpark_pkg;

    // Per-output leg state
    typedef enum logic [1:0] {
        LEG_FLOAT  = 2'd0,
        LEG_PARKHI = 2'd1,
        LEG_RUN    = 2'd2
    } leg_st_e;

    // Reference phase generator state
    typedef struct packed {
        logic ph;   // true-leg phase
        logic pre;  // half-rate prescaler
    } phase_s;

endpackage

// File: rtl/clkpark_phase.sv
module clkpark_phase
    import clkpark_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_rate,
    output logic ph,
    output logic fall_evt,   // next edge: complement falls (true rises)
    output logic rise_evt    // next edge: complement rises (true falls)
);

    phase_s q, d;
    logic   step;

    always_comb begin
        d    = q;
        step = full_rate | q.pre;
        d.pre = full_rate ? 1'b0 : ~q.pre;
        if (step) begin
            d.ph = ~q.ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ph       = q.ph;
    assign fall_evt = step & ~q.ph;
    assign rise_evt = step &  q.ph;

endmodule

// File: rtl/clkpark_pdq.sv
module clkpark_pdq #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic rise_evt,
    output logic pd_req
);

    localparam int CW = $clog2(QUAL_EDGES + 1);
    localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_EDGES);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
    } pdq_s;

    pdq_s q, d;
    logic pd_s;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], pd_n};
        pd_s   = q.sync[SYNC_STAGES-1];
        if (rise_evt) begin
            if (pd_s) begin
                d.cnt = '0;
            end else if (q.cnt != QUAL_MAX) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign pd_req = (q.cnt == QUAL_MAX);

endmodule

// File: rtl/clkpark_leg.sv
module clkpark_leg
    import clkpark_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph,
    input  logic fall_evt,
    input  logic pd_req,
    input  logic en,
    input  logic stoppable,
    input  logic oe_n,
    input  logic oe_float,
    input  logic pd_float,
    output logic t,
    output logic c,
    output logic t_en,
    output logic c_en
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] oe_sync;
        leg_st_e                st;
    } leg_s;

    leg_s q, d;
    logic oe_s;
    logic want;

    always_comb begin
        d         = q;
        d.oe_sync = {q.oe_sync[SYNC_STAGES-2:0], oe_n};
        oe_s      = q.oe_sync[SYNC_STAGES-1];
        want      = en & (~stoppable | ~oe_s);
        if (fall_evt) begin
            if (pd_req) begin
                d.st = pd_float ? LEG_FLOAT : LEG_PARKHI;
            end else if (want) begin
                d.st = LEG_RUN;
            end else begin
                d.st = oe_float ? LEG_FLOAT : LEG_PARKHI;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.oe_sync <= '1;
            q.st      <= LEG_FLOAT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            LEG_RUN: begin
                t = ph;   c = ~ph;  t_en = 1'b1; c_en = 1'b1;
            end
            LEG_PARKHI: begin
                t = 1'b1; c = 1'b0; t_en = 1'b1; c_en = 1'b0;
            end
            default: begin
                t = 1'b0; c = 1'b0; t_en = 1'b0; c_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkpark_ctrl.sv
module clkpark_ctrl
    import clkpark_pkg::*;
#(
    parameter int NUM_OUT     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               full_rate,
    input  logic               pd_n,
    input  logic [NUM_OUT-1:0] oe_n,
    input  logic [NUM_OUT-1:0] reg_en,
    input  logic [NUM_OUT-1:0] reg_stop,
    input  logic               oe_park_float,
    input  logic               pd_park_float,
    output logic [NUM_OUT-1:0] out_t,
    output logic [NUM_OUT-1:0] out_c,
    output logic [NUM_OUT-1:0] out_t_en,
    output logic [NUM_OUT-1:0] out_c_en
);

    logic ph, fall_evt, rise_evt, pd_req;

    clkpark_phase phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_rate(full_rate),
        .ph       (ph),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt)
    );

    clkpark_pdq #(
        .SYNC_STAGES(SYNC_STAGES),
        .QUAL_EDGES (QUAL_EDGES)
    ) pdq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .rise_evt(rise_evt),
        .pd_req  (pd_req)
    );

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_leg
        clkpark_leg #(.SYNC_STAGES(SYNC_STAGES)) leg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ph       (ph),
            .fall_evt (fall_evt),
            .pd_req   (pd_req),
            .en       (reg_en[gi]),
            .stoppable(reg_stop[gi]),
            .oe_n     (oe_n[gi]),
            .oe_float (oe_park_float),
            .pd_float (pd_park_float),
            .t        (out_t[gi]),
            .c        (out_c[gi]),
            .t_en     (out_t_en[gi]),
            .c_en     (out_c_en[gi])
        );
    end

endmodule

// File: rtl/clkpark_ctrl_chk.sv
module clkpark_ctrl_chk #(
    parameter int NUM_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OUT-1:0] reg_en,
    input logic [NUM_OUT-1:0] out_t,
    input logic [NUM_OUT-1:0] out_c,
    input logic [NUM_OUT-1:0] out_t_en,
    input logic [NUM_OUT-1:0] out_c_en
);

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_chk
        // R3
        pair_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_c_en[gi] |-> (out_t_en[gi] && (out_c[gi] != out_t[gi])));

        // R5
        park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_t_en[gi] && !out_c_en[gi]) |-> out_t[gi]);

        // R8
        start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_c_en[gi]) |-> out_t[gi]);

        // R8
        stop_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(out_c_en[gi]) |-> !$past(out_t[gi]));

        // R2
        start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_c_en[gi]) |-> $past(reg_en[gi]));
    end

endmodule

bind clkpark_ctrl clkpark_ctrl_chk #(.NUM_OUT(NUM_OUT)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_en  (reg_en),
    .out_t   (out_t),
    .out_c   (out_c),
    .out_t_en(out_t_en),
    .out_c_en(out_c_en)
);

// File: tb/clkpark_ctrl_tb_top.sv
module clkpark_ctrl_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         full_rate = 1'b1;
    logic         pd_n = 1'b1;
    logic [N-1:0] oe_n = '1;
    logic [N-1:0] reg_en = '0;
    logic [N-1:0] reg_stop = '0;
    logic         oe_park_float = 1'b0;
    logic         pd_park_float = 1'b0;
    logic [N-1:0] out_t, out_c, out_t_en, out_c_en;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    logic [N-1:0] prev_t, prev_cen;

    always #5 clk = ~clk;

    clkpark_ctrl #(.NUM_OUT(N), .SYNC_STAGES(2), .QUAL_EDGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .full_rate(full_rate), .pd_n(pd_n),
        .oe_n(oe_n), .reg_en(reg_en), .reg_stop(reg_stop),
        .oe_park_float(oe_park_float), .pd_park_float(pd_park_float),
        .out_t(out_t), .out_c(out_c), .out_t_en(out_t_en), .out_c_en(out_c_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] gate(input logic [N-1:0] en,
                                          input logic [N-1:0] stp,
                                          input logic [N-1:0] oe);
        return en & (~stp | ~oe);
    endfunction

    // R8: every run/park transition sits on a true-leg rising edge
    always @(negedge clk) begin
        if (mon_en) begin
            for (int i = 0; i < N; i++) begin
                if (prev_cen[i] && !out_c_en[i])
                    chk(prev_t[i] == 1'b0, "R8 stop phase", int'(prev_t[i]), 0);
                if (!prev_cen[i] && out_c_en[i])
                    chk(out_t[i] == 1'b1, "R8 start phase", int'(out_t[i]), 1);
            end
        end
        prev_t   = out_t;
        prev_cen = out_c_en;
    end

    // Apply a rotated gating pattern: output i gets combo (i+k)%8
    task automatic apply_pattern(input int k);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            int cb;
            cb = (i + k) % 8;
            reg_en[i]   = cb[0];
            reg_stop[i] = cb[1];
            oe_n[i]     = cb[2];
        end
    endtask

    task automatic wait_match(input logic [N-1:0] exp, input int limit, input string req);
        int n;
        n = 0;
        while (out_c_en !== exp && n <= limit) begin
            @(negedge clk);
            n++;
        end
        chk(out_c_en === exp && n <= limit, req, n, limit);
    endtask

    task automatic steady(input logic [N-1:0] run, input logic fl, input string park_req);
        int tog [N];
        bit bad [N];
        logic [N-1:0] pt;
        for (int i = 0; i < N; i++) begin tog[i] = 0; bad[i] = 1'b0; end
        pt = out_t;
        for (int s = 0; s < 9; s++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (run[i]) begin
                    if (!(out_t_en[i] && out_c_en[i] && out_c[i] != out_t[i])) bad[i] = 1'b1;
                    if (s > 0 && out_t[i] != pt[i]) tog[i]++;
                end else begin
                    if (out_c_en[i] || out_t_en[i] != !fl || (!fl && out_t[i] !== 1'b1))
                        bad[i] = 1'b1;
                end
            end
            pt = out_t;
        end
        for (int i = 0; i < N; i++) begin
            if (run[i]) begin
                chk(!bad[i], "R3 running pair", int'(out_c_en[i]), 1);
                chk(tog[i] == (full_rate ? 8 : 4), "R4 toggle rate", tog[i], full_rate ? 8 : 4);
            end else begin
                chk(!bad[i], park_req, int'(out_t_en[i]), int'(!fl));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] exp;
        int per;
        int n;
        bit early;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_t_en == '0 && out_c_en == '0, "R1 reset float", int'(out_t_en | out_c_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        mon_en = 1'b1;

        // R2/R5/R9 sweep over rates, stop park style and gating combos
        for (int fr = 1; fr >= 0; fr--) begin
            for (int of = 0; of < 2; of++) begin
                @(negedge clk);
                full_rate = fr[0];
                oe_park_float = of[0];
                per = fr ? 2 : 4;
                for (int k = 0; k < 8; k++) begin
                    apply_pattern(k);
                    exp = gate(reg_en, reg_stop, oe_n);
                    wait_match(exp, 3 * per, "R9 latency / R2 gating");
                    repeat (2 * per) @(negedge clk);
                    steady(exp, oe_park_float, "R5 stop park");
                end
            end
        end

        // R2: pin toggle on a free-running output has no effect
        apply_pattern(1);
        reg_en = '1; reg_stop = '0; oe_n = '0;
        repeat (16) @(negedge clk);
        oe_n = '1;
        repeat (16) @(negedge clk);
        chk(out_c_en == '1, "R2 free-run ignores pin", int'(out_c_en), (1 << N) - 1);

        // R6/R7/R10 power-down
        for (int fr = 1; fr >= 0; fr--) begin
            for (int pf = 0; pf < 2; pf++) begin
                @(negedge clk);
                full_rate = fr[0];
                pd_park_float = pf[0];
                oe_park_float = 1'b0;
                per = fr ? 2 : 4;
                apply_pattern(3);
                exp = gate(reg_en, reg_stop, oe_n);
                wait_match(exp, 3 * per, "R9 settle before pd");
                repeat (2 * per) @(negedge clk);
                // R7: two-cycle pulse spans one complement rising edge only
                pd_n = 1'b0;
                repeat (2) @(negedge clk);
                pd_n = 1'b1;
                early = 1'b0;
                for (int s = 0; s < 20; s++) begin
                    @(negedge clk);
                    if (out_c_en !== exp) early = 1'b1;
                end
                chk(!early, "R7 short pulse ignored", int'(out_c_en), int'(exp));
                // R7: qualified power-down
                pd_n = 1'b0;
                n = 0;
                while (out_c_en !== '0 && n <= 8 * per) begin
                    @(negedge clk);
                    n++;
                end
                chk(out_c_en === '0 && n > 2 && n <= 8 * per, "R7 qualified pd", n, 8 * per);
                repeat (2) @(negedge clk);
                steady('0, pd_park_float, "R6 pd park");
                // R10: change settings while down, then release
                apply_pattern(6);
                oe_park_float = 1'b1;
                repeat (4 * per) @(negedge clk);
                chk(out_c_en === '0, "R6 stays parked", int'(out_c_en), 0);
                pd_n = 1'b1;
                exp = gate(reg_en, reg_stop, oe_n);
                wait_match(exp, 4 * per, "R10 resume");
                repeat (2 * per) @(negedge clk);
                steady(exp, 1'b1, "R10 fresh park style");
            end
        end

        mon_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule